// File: doc/BRIEF.md
# Local Bus Hold Arbiter

This block lets a second bus master borrow the local bus from the processor's bus cycle sequencer. It samples a hold request that is synchronous to the clock and has no internal synchronizer. It grants the request only at a point where handing over the bus cannot cut a transfer in half. When it grants, it raises the acknowledge and releases the address/data bus and the bus control strobes on the same clock edge.

While the bus is held, the released control strobes present an all-ones value. Downstream this reads as a weak logic one, not an undefined level. The address latch strobe and the interrupt acknowledge strobe are never released. When the request goes away, the acknowledge falls at once. The bus stays released until the sequencer asks to run another cycle.

The sequencer reports its current T-state and whether it wants to begin a cycle. It receives back a stall signal that holds off any new cycle while a grant is pending or in force. All outputs except the stall are registered.

Top module: `hold_arbiter`

## Requirements
- R1: After synchronous reset the acknowledge is low, both output enables are high, the address/data output is zero, the control output is all ones, the latch strobe output is low and the acknowledge-strobe output is high.
- R2: A hold request is granted only when the reported T-state is a grant slot: idle (code 0), T1 (code 1) or T4 (code 5). The acknowledge rises on the clock edge that samples the request in that slot. A request seen during T2 (2), T3 (3) or a wait state (4) is not granted until the cycle reaches T4.
- R3: On the edge where the acknowledge rises, the address/data enable and the control enable fall. While the bus is released, the address/data output holds its last driven value.
- R4: While the control enable is low, every bit of the control output is one.
- R5: If the request is sampled low while acknowledged, the acknowledge falls on that edge and both enables stay low.
- R6: After a release, the enables return high only on an edge that samples the cycle request high with the hold request low. If the hold request returns first, the acknowledge rises again on that edge without the bus being driven.
- R7: The stall output is high whenever the bus is not driven. While the bus is driven, the stall output is high in the same cycle as a hold request that coincides with a grant slot, so that no new cycle starts.
- R8: The latch strobe and acknowledge-strobe outputs follow their inputs one clock later at all times, including while the bus is held.
- R9: While the bus is driven, the address/data and control outputs follow their inputs one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hold_req | input | 1 | Hold request from the other master, synchronous, active high |
| seq_tstate | input | 3 | Sequencer T-state: 0 idle, 1 T1, 2 T2, 3 T3, 4 wait, 5 T4 |
| seq_cyc_req | input | 1 | Sequencer wants to begin a bus cycle |
| seq_stall | output | 1 | Hold off the sequencer (grant pending or bus not owned) |
| hlda | output | 1 | Hold acknowledge |
| ad_in | input | AD_W | Address/data value from the sequencer |
| ad_out | output | AD_W | Registered address/data output |
| ad_oe | output | 1 | Address/data output enable |
| ctl_in | input | CTL_W | Releasable control strobes from the sequencer |
| ctl_out | output | CTL_W | Registered control strobes, all ones while released |
| ctl_oe | output | 1 | Control output enable |
| ale_in | input | 1 | Address latch strobe from the sequencer |
| ale_out | output | 1 | Registered address latch strobe, never released |
| inta_n_in | input | 1 | Interrupt acknowledge strobe (active low) from the sequencer |
| inta_n_out | output | 1 | Registered interrupt acknowledge strobe, never released |

## Verification
The assertions assume that the hold request and the sequencer inputs change only between clock edges, since there is no synchronizer. They also assume that the T-state input carries one of the six defined codes. The bench drives every input on the falling edge. It draws T-state codes only from the defined set, and it changes the hold request with low probability, so that long held and long driven stretches both occur. Directed sequences place a request in every T-state and run a drop-and-reassert of the request with and without a pending cycle request.

// File: rtl/hold_arb_pkg.sv
package hold_arb_pkg;

  typedef enum logic [2:0] {
    TS_IDLE = 3'd0,
    TS_T1   = 3'd1,
    TS_T2   = 3'd2,
    TS_T3   = 3'd3,
    TS_TW   = 3'd4,
    TS_T4   = 3'd5
  } tstate_e;

  typedef enum logic [1:0] {
    OWN_DRIVE = 2'd0,
    OWN_HELD  = 2'd1,
    OWN_WAIT  = 2'd2
  } own_e;

  function automatic logic is_grant_slot(input logic [2:0] ts);
    return (ts == TS_IDLE) || (ts == TS_T1) || (ts == TS_T4);
  endfunction

endpackage

// File: rtl/hold_fsm.sv
module hold_fsm
  import hold_arb_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       hold_req,
  input  logic [2:0] tstate,
  input  logic       cyc_req,
  output own_e       st_q,
  output own_e       st_n,
  output logic       stall
);

  logic slot;
  assign slot = is_grant_slot(tstate);

  always_comb begin
    st_n = st_q;
    case (st_q)
      OWN_DRIVE: if (hold_req && slot) st_n = OWN_HELD;
      OWN_HELD:  if (!hold_req)        st_n = OWN_WAIT;
      OWN_WAIT: begin
        if (hold_req)     st_n = OWN_HELD;
        else if (cyc_req) st_n = OWN_DRIVE;
      end
      default:            st_n = OWN_DRIVE;
    endcase
  end

  assign stall = (st_q != OWN_DRIVE) || (hold_req && slot);

  always_ff @(posedge clk) begin
    if (rst) st_q <= OWN_DRIVE;
    else     st_q <= st_n;
  end

  // R6: the waiting state is only entered from the held state
  p_wait_entry_r6: assert property (@(posedge clk) disable iff (rst)
    (st_q == OWN_WAIT && $past(st_q) != OWN_WAIT) |-> $past(st_q) == OWN_HELD);

endmodule

// File: rtl/bus_park.sv
module bus_park #(
  parameter int          W         = 8,
  parameter bit          PARK_ONES = 1'b0,
  parameter logic [W-1:0] RST_VAL  = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         drive_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         oe
);

  always_ff @(posedge clk) begin
    if (rst) oe <= 1'b1;
    else     oe <= drive_n;
  end

  generate
    if (PARK_ONES) begin : g_ones
      always_ff @(posedge clk) begin
        if (rst)          q <= RST_VAL;
        else if (drive_n) q <= d;
        else              q <= '1;
      end
      // R4: released control lines read as all ones
      p_park_ones_r4: assert property (@(posedge clk) disable iff (rst)
        !oe |-> (q == {W{1'b1}}));
    end else begin : g_keep
      always_ff @(posedge clk) begin
        if (rst)          q <= RST_VAL;
        else if (drive_n) q <= d;
      end
      // R3: released bus keeps its last driven value
      p_keep_value_r3: assert property (@(posedge clk) disable iff (rst)
        !drive_n |=> $stable(q));
    end
  endgenerate

endmodule

// File: rtl/hold_arbiter.sv
module hold_arbiter
  import hold_arb_pkg::*;
#(
  parameter int AD_W  = 20,
  parameter int CTL_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold_req,
  input  logic [2:0]       seq_tstate,
  input  logic             seq_cyc_req,
  output logic             seq_stall,
  output logic             hlda,
  input  logic [AD_W-1:0]  ad_in,
  output logic [AD_W-1:0]  ad_out,
  output logic             ad_oe,
  input  logic [CTL_W-1:0] ctl_in,
  output logic [CTL_W-1:0] ctl_out,
  output logic             ctl_oe,
  input  logic             ale_in,
  output logic             ale_out,
  input  logic             inta_n_in,
  output logic             inta_n_out
);

  localparam logic [CTL_W-1:0] CTL_IDLE = {CTL_W{1'b1}};

  own_e st_q, st_n;
  logic drive_n;

  hold_fsm u_fsm (
    .clk      (clk),
    .rst      (rst),
    .hold_req (hold_req),
    .tstate   (seq_tstate),
    .cyc_req  (seq_cyc_req),
    .st_q     (st_q),
    .st_n     (st_n),
    .stall    (seq_stall)
  );

  assign drive_n = (st_n == OWN_DRIVE);

  bus_park #(.W(AD_W), .PARK_ONES(1'b0), .RST_VAL('0)) u_ad (
    .clk (clk), .rst (rst), .drive_n (drive_n),
    .d (ad_in), .q (ad_out), .oe (ad_oe)
  );

  bus_park #(.W(CTL_W), .PARK_ONES(1'b1), .RST_VAL(CTL_IDLE)) u_ctl (
    .clk (clk), .rst (rst), .drive_n (drive_n),
    .d (ctl_in), .q (ctl_out), .oe (ctl_oe)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hlda       <= 1'b0;
      ale_out    <= 1'b0;
      inta_n_out <= 1'b1;
    end else begin
      hlda       <= (st_n == OWN_HELD);
      ale_out    <= ale_in;
      inta_n_out <= inta_n_in;
    end
  end

  // R2: a grant from the driven bus happens only at a grant slot
  p_grant_slot_r2: assert property (@(posedge clk) disable iff (rst)
    ($rose(hlda) && $past(ad_oe)) |-> ($past(hold_req) && is_grant_slot($past(seq_tstate))));

  // R3: bus and controls are released whenever acknowledged
  p_float_on_hlda_r3: assert property (@(posedge clk) disable iff (rst)
    hlda |-> (!ad_oe && !ctl_oe));

  // R5: dropped request clears the acknowledge on the next edge, bus stays released
  p_drop_r5: assert property (@(posedge clk) disable iff (rst)
    (hlda && !hold_req) |=> (!hlda && !ad_oe));

  // R6: no re-drive without a cycle request
  p_no_redrive_r6: assert property (@(posedge clk) disable iff (rst)
    (!ad_oe && (!seq_cyc_req || hold_req)) |=> !ad_oe);

  // R7: sequencer stalled whenever the bus is not owned
  p_stall_r7: assert property (@(posedge clk) disable iff (rst)
    !ad_oe |-> seq_stall);

  // R8: strobes that are never released keep following their inputs
  p_strobe_follow_r8: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (ale_out == $past(ale_in) && inta_n_out == $past(inta_n_in)));

endmodule

// File: tb/hold_arbiter_bench.sv
module hold_arbiter_bench;

  localparam int AD_W  = 20;
  localparam int CTL_W = 5;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             hold_req = 1'b0;
  logic [2:0]       seq_tstate = 3'd0;
  logic             seq_cyc_req = 1'b0;
  logic             seq_stall, hlda, ad_oe, ctl_oe, ale_out, inta_n_out;
  logic [AD_W-1:0]  ad_in = '0, ad_out;
  logic [CTL_W-1:0] ctl_in = '0, ctl_out;
  logic             ale_in = 1'b0, inta_n_in = 1'b1;

  always #4 clk = ~clk;

  hold_arbiter #(.AD_W(AD_W), .CTL_W(CTL_W)) u_hold_arbiter (
    .clk (clk), .rst (rst), .hold_req (hold_req), .seq_tstate (seq_tstate),
    .seq_cyc_req (seq_cyc_req), .seq_stall (seq_stall), .hlda (hlda),
    .ad_in (ad_in), .ad_out (ad_out), .ad_oe (ad_oe),
    .ctl_in (ctl_in), .ctl_out (ctl_out), .ctl_oe (ctl_oe),
    .ale_in (ale_in), .ale_out (ale_out),
    .inta_n_in (inta_n_in), .inta_n_out (inta_n_out)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference model: 0 driven, 1 held, 2 released-waiting
  int              m_st = 0;
  logic [AD_W-1:0] m_ad = '0;
  logic [CTL_W-1:0] m_ctl = '1;

  function automatic bit slot_f(input logic [2:0] ts);
    return (ts == 3'd0) || (ts == 3'd1) || (ts == 3'd5);
  endfunction

  function automatic int next_f(input int st, input bit h, input logic [2:0] ts, input bit c);
    if (st == 0) return (h && slot_f(ts)) ? 1 : 0;
    if (st == 1) return h ? 1 : 2;
    if (h) return 1;
    return c ? 0 : 2;
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic step(input bit h, input logic [2:0] ts, input bit c,
                      input logic [AD_W-1:0] ad, input logic [CTL_W-1:0] ctl,
                      input bit a, input bit ia);
    int ns;
    @(negedge clk);
    hold_req = h; seq_tstate = ts; seq_cyc_req = c;
    ad_in = ad; ctl_in = ctl; ale_in = a; inta_n_in = ia;
    #1;
    chk("R7 stall", seq_stall, (m_st != 0) || (h && slot_f(ts)));
    ns = next_f(m_st, h, ts, c);
    if (ns == 0) begin m_ad = ad; m_ctl = ctl; end
    else m_ctl = '1;
    m_st = ns;
    @(posedge clk); #1;
    chk("R2 R5 R6 hlda", hlda, m_st == 1);
    chk("R3 R6 ad_oe", ad_oe, m_st == 0);
    chk("R3 ctl_oe", ctl_oe, m_st == 0);
    chk("R3 R9 ad_out", ad_out, m_ad);
    chk("R4 R9 ctl_out", ctl_out, m_ctl);
    chk("R8 ale_out", ale_out, a);
    chk("R8 inta_n_out", inta_n_out, ia);
  endtask

  task automatic rstep(input bit h, input logic [2:0] ts, input bit c);
    step(h, ts, c, AD_W'($urandom), CTL_W'($urandom), 1'($urandom), 1'($urandom));
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (5) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    // R1 reset state
    chk("R1 hlda", hlda, 0);
    chk("R1 ad_oe", ad_oe, 1);
    chk("R1 ctl_oe", ctl_oe, 1);
    chk("R1 ad_out", ad_out, 0);
    chk("R1 ctl_out", ctl_out, 5'h1f);
    chk("R1 ale_out", ale_out, 0);
    chk("R1 inta_n_out", inta_n_out, 1);

    // R2: hold request arriving in each T-state
    for (int ts = 0; ts < 6; ts++) begin
      rstep(1'b1, 3'(ts), 1'b0);
      chk("R2 grant only in slot", hlda, slot_f(3'(ts)));
      if (!hlda) begin
        rstep(1'b1, 3'd5, 1'b0);
        chk("R2 deferred grant at T4", hlda, 1);
      end
      rstep(1'b0, 3'd0, 1'b0);
      chk("R5 drop clears hlda", hlda, 0);
      chk("R5 bus still released", ad_oe, 0);
      rstep(1'b0, 3'd0, 1'b1);
      chk("R6 re-drive on cycle request", ad_oe, 1);
    end

    // R6: drop then reassert without a cycle request
    rstep(1'b1, 3'd1, 1'b0);
    rstep(1'b0, 3'd0, 1'b0);
    rstep(1'b0, 3'd0, 1'b0);
    chk("R6 stays released without request", ad_oe, 0);
    rstep(1'b1, 3'd2, 1'b1);
    chk("R6 regrant while released", hlda, 1);
    chk("R6 no drive on regrant", ad_oe, 0);
    rstep(1'b0, 3'd0, 1'b1);
    rstep(1'b0, 3'd0, 1'b1);
    chk("R6 drive after release and request", ad_oe, 1);

    // constrained random
    for (int n = 0; n < 4000; n++) begin
      bit h;
      h = (($urandom % 8) == 0) ? ~hold_req : hold_req;
      rstep(h, 3'($urandom % 6), 1'($urandom % 2));
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule